// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial-memory protocol engine and collects the data bytes of one write transaction into a small page buffer. The engine flags the start of a write together with the target address, then presents each received data byte. Only the low slot bits of the address advance from byte to byte, so a long burst wraps inside its page. A later byte that lands in an occupied slot replaces the earlier one.

When the engine reports the STOP that closes the write, the block commits every slot that was filled to the storage array. This takes one self-timed programming interval. A busy flag stays high for a fixed number of system clocks, and the engine uses it to refuse new traffic. The array write strobes are issued one slot per cycle, in ascending slot order, at the start of that interval. A write-protect pin guards the upper half of the array. A page there still accepts its bytes, but nothing reaches the array.

Top module: `page_commit_buf`

## Requirements
- R1: After reset, `busy` is low and `memWe` is low, and `memWe` is never high while `busy` is low.
- R2: Each `wrStart` pulse taken while not busy discards every byte captured before it. Only bytes received after the latest start are committed.
- R3: A data byte is stored at slot = (base address low 4 bits + bytes received before it) mod 16. The array address is the base address with its low 4 bits replaced by the slot, so the high-order bits never change within a write.
- R4: When more than 16 bytes arrive before STOP, the pointer wraps. A slot written twice is committed once, carrying the latest byte.
- R5: Starting the cycle after STOP, `memWe` pulses once for each filled slot, in ascending slot order (slot 0 first), with `memAddr`/`memData` giving that slot's address and byte.
- R6: After a STOP that ends a write holding at least one byte, `busy` rises in the next cycle and stays high for exactly `WRITE_CYCLES` cycles.
- R7: A STOP ending a write with no data byte leaves `busy` low and issues no strobe.
- R8: If `wpIn` is high at STOP and the base address's top bit is 1, the busy interval still runs but no strobe is issued. With `wpIn` low, the same page is written normally.
- R9: While `busy` is high, `wrStart`, `byteValid` and `stopSeen` are ignored. After busy ends, no strobe or busy interval results from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStart | input | 1 | One-cycle pulse: a write begins at `wrBase` |
| wrBase | input | ADDR_W | Base array address of the write |
| byteValid | input | 1 | One-cycle pulse: `byteData` holds a data byte |
| byteData | input | DATA_W | Received data byte |
| stopSeen | input | 1 | One-cycle pulse: STOP ended the write |
| wpIn | input | 1 | Write-protect for the upper half of the array |
| busy | output | 1 | High during the programming interval |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array address for the strobe |
| memData | output | DATA_W | Array data for the strobe |

## Verification
Inputs are driven on the falling edge and sampled by the block on the next rising edge. A STOP sampled at edge k therefore makes `busy` and the first strobe (slot 0 position) visible from the following falling edge, and the strobe for slot i appears i cycles later. The scoreboard queues the expected address/data pairs at STOP and compares them only on falling edges where `memWe` is high. It counts the falling edges with `busy` high and expects exactly `WRITE_CYCLES`, and requires the queue to be empty when busy falls. Cases with no commit are checked by watching `busy` for several cycles after the STOP.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  localparam int PAGE_BYTES = 16;
  localparam int SLOT_W     = $clog2(PAGE_BYTES);

  typedef struct packed {
    logic              loadBase;   // latch base, clear valid bits
    logic              capture;    // store a data byte, advance pointer
    logic              latchProt;  // sample write-protect at commit
    logic              sweepEn;    // commit sweep active
    logic [SLOT_W-1:0] sweepIdx;   // slot being committed
  } strobe_t;
endpackage

// File: rtl/page_commit_dp.sv
module page_commit_dp
  import page_commit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [DATA_W-1:0] byteData,
  input  logic              wpIn,
  output logic              anyValid,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int HI_W = ADDR_W - SLOT_W;

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validBits;
  logic [HI_W-1:0]       baseHi;
  logic [SLOT_W-1:0]     slotPtr;
  logic                  protLatched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits   <= '0;
      baseHi      <= '0;
      slotPtr     <= '0;
      protLatched <= 1'b0;
    end else begin
      if (strobes.loadBase) begin
        validBits <= '0;
        baseHi    <= wrBase[ADDR_W-1:SLOT_W];
        slotPtr   <= wrBase[SLOT_W-1:0];
      end else if (strobes.capture) begin
        validBits[slotPtr] <= 1'b1;
        slotPtr            <= slotPtr + 1'b1;
      end
      if (strobes.latchProt)
        protLatched <= wpIn & baseHi[HI_W-1];
    end
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (strobes.capture && !strobes.loadBase && slotPtr == SLOT_W'(g))
          pageBuf[g] <= byteData;
      end
    end
  endgenerate

  assign anyValid = |validBits;
  assign memWe    = strobes.sweepEn & validBits[strobes.sweepIdx] & ~protLatched;
  assign memAddr  = {baseHi, strobes.sweepIdx};
  assign memData  = pageBuf[strobes.sweepIdx];

  // R9: captured state is frozen while the commit sweep runs
  a_r9_frozen_in_sweep: assert property (@(posedge clk) disable iff (!rstN)
    strobes.sweepEn |=> $stable(validBits));
  // R2: a fresh start leaves no captured byte behind
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBase |=> !anyValid);
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import page_commit_pkg::*;
#(
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStart,
  input  logic    byteValid,
  input  logic    stopSeen,
  input  logic    anyValid,
  output strobe_t strobes,
  output logic    busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_BUSY} state_t;
  state_t            state;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE:    if (wrStart) state <= S_COLLECT;
        S_COLLECT: if (stopSeen) begin
                     state <= anyValid ? S_BUSY : S_IDLE;
                     cnt   <= '0;
                   end
        S_BUSY:    if (cnt == LAST_CNT) state <= S_IDLE;
                   else cnt <= cnt + 1'b1;
        default:   state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes           = '0;
    strobes.loadBase  = wrStart & (state != S_BUSY);
    strobes.capture   = byteValid & ~stopSeen & (state == S_COLLECT);
    strobes.latchProt = stopSeen & (state == S_COLLECT);
    strobes.sweepEn   = (state == S_BUSY) && (cnt < CNT_W'(PAGE_BYTES));
    strobes.sweepIdx  = cnt[SLOT_W-1:0];
  end

  assign busy = (state == S_BUSY);

  // R6: busy is held until the full interval has elapsed
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != LAST_CNT) |=> busy);
  // R7: an empty write never opens a programming interval
  a_r7_empty_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_COLLECT && stopSeen && !anyValid) |=> !busy);
endmodule

// File: rtl/page_commit_buf.sv
module page_commit_buf
  import page_commit_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopSeen,
  input  logic              wpIn,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  strobe_t strobes;
  logic    anyValid;

  page_commit_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .byteValid(byteValid),
    .stopSeen(stopSeen), .anyValid(anyValid), .strobes(strobes), .busy(busy)
  );

  page_commit_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBase(wrBase),
    .byteData(byteData), .wpIn(wpIn), .anyValid(anyValid),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  // R1: no array strobe outside the busy interval
  a_r1_we_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
  // R3: consecutive strobes of one commit share the page bits
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |->
      memAddr[ADDR_W-1:SLOT_W] == $past(memAddr[ADDR_W-1:SLOT_W]));
endmodule

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WC = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStart = 1'b0, byteValid = 1'b0, stopSeen = 1'b0, wpIn = 1'b0;
  logic [AW-1:0] wrBase = '0;
  logic [DW-1:0] byteData = '0;
  logic busy, memWe;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_commit_buf #(.ADDR_W(AW), .DATA_W(DW), .WRITE_CYCLES(WC)) u_dut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrBase(wrBase),
    .byteValid(byteValid), .byteData(byteData), .stopSeen(stopSeen),
    .wpIn(wpIn), .busy(busy), .memWe(memWe), .memAddr(memAddr),
    .memData(memData)
  );

  // reference model
  logic [DW-1:0] mData [16];
  logic [15:0]   mValid;
  logic [AW-1:0] mBase;
  logic [3:0]    mPtr;
  logic [AW+DW-1:0] expQ [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic beginWrite(input logic [AW-1:0] base);
    @(negedge clk);
    wrStart = 1'b1; wrBase = base;
    @(negedge clk);
    wrStart = 1'b0;
    mValid = '0; mBase = base; mPtr = base[3:0];
  endtask

  task automatic sendByte(input logic [DW-1:0] d);
    @(negedge clk);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
    mData[mPtr] = d; mValid[mPtr] = 1'b1; mPtr = mPtr + 1'b1;
  endtask

  // drives STOP; queues the expected strobes; checks busy rise (R6/R7/R8)
  task automatic stopWrite();
    @(negedge clk);
    stopSeen = 1'b1;
    if (!(wpIn && mBase[AW-1]))
      for (int i = 0; i < 16; i++)
        if (mValid[i]) expQ.push_back({mBase[AW-1:4], 4'(i), mData[i]});
    @(negedge clk);
    stopSeen = 1'b0;
    if (mValid != 0) check(busy === 1'b1, "R6 busy rise", busy, 1);
    else begin
      for (int k = 0; k < 6; k++) begin
        check(busy === 1'b0, "R7 empty write busy", busy, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  int busyRun = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (memWe) begin
        if (!busy) check(1'b0, "R1 strobe outside busy", 1, 0);
        if (expQ.size() == 0) check(1'b0, "R5/R8/R9 unexpected strobe", {memAddr, memData}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = expQ.pop_front();
          check({memAddr, memData} == e, "R3/R4/R5 strobe addr+data", {memAddr, memData}, e);
        end
      end
      if (busy) busyRun++;
      else if (busyRun != 0) begin
        check(busyRun == WC, "R6 busy length", busyRun, WC);
        check(expQ.size() == 0, "R5 missing strobes", expQ.size(), 0);
        busyRun = 0;
      end
    end
  end

  initial begin
    #(4 * 200000);
    check(1'b0, "watchdog", 0, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(memWe === 1'b0, "R1 reset memWe", memWe, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && memWe === 1'b0, "R1 after reset", busy, 0);

    // R3/R5: simple three-byte write
    beginWrite(8'h20);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3);
    stopWrite(); waitIdle();

    // R3: base inside page, pointer wraps low bits, order by slot
    beginWrite(8'h4D);
    for (int i = 0; i < 5; i++) sendByte(8'h60 + 8'(i));
    stopWrite(); waitIdle();

    // R4: 20 bytes overwrite slots 0..3
    beginWrite(8'h10);
    for (int i = 0; i < 20; i++) sendByte(8'h80 + 8'(i));
    stopWrite(); waitIdle();

    // R2: restart discards earlier bytes
    beginWrite(8'h30);
    sendByte(8'h11); sendByte(8'h22);
    beginWrite(8'h57);
    sendByte(8'h33);
    stopWrite(); waitIdle();

    // R7: address only
    beginWrite(8'h44);
    stopWrite(); waitIdle();

    // R8: protected upper page, busy but no strobes
    wpIn = 1'b1;
    beginWrite(8'h90);
    sendByte(8'hC1); sendByte(8'hC2);
    stopWrite();
    check(memWe === 1'b0, "R8 protected no strobe", memWe, 0);
    waitIdle();
    // R8: lower half still writable with wp high
    beginWrite(8'h12);
    sendByte(8'hD4);
    stopWrite(); waitIdle();
    wpIn = 1'b0;
    // R8: upper half writable with wp low
    beginWrite(8'hA3);
    sendByte(8'hE5);
    stopWrite();
    // R9: traffic during busy is ignored
    @(negedge clk); wrStart = 1'b1; wrBase = 8'h05;
    @(negedge clk); wrStart = 1'b0; byteValid = 1'b1; byteData = 8'hFF;
    @(negedge clk); byteValid = 1'b0; stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
    waitIdle();
    for (int k = 0; k < 8; k++) begin
      check(busy === 1'b0 && memWe === 1'b0, "R9 no commit from busy traffic", busy, 0);
      @(negedge clk);
    end
    check(expQ.size() == 0, "R9 queue drained", expQ.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule